// File: doc/BRIEF.md
# Switching-Cycle Clock Source Selector

This block decides where the start of every switching cycle of a converter controller comes from. Two sources are available: a free-running internal oscillator, delivered as a one-clock tick in the system clock domain, and an asynchronous external sync pin. The internal cycle is formed by counting a fixed number of oscillator ticks. After reset the internal source drives the cycle-start strobe. The internal oscillator nominally gives about 750 kHz cycles, and the external clock may lie anywhere between 500 kHz and 1 MHz.

The first rising edge seen on the sync pin locks the block to the external source. From then on every external rising edge produces exactly one cycle start. Each external edge also restarts the internal phase, so the internal period measures the time since the last edge. If a fixed number of internal periods pass with no external edge, the block falls back to the internal source. It emits one cycle start at the moment of fallback and then continues with internal cycles at the normal spacing. No pulse is doubled, and the cycle stream never stops for good.

The sync pin is sampled through a synchronizer. Only its rising edges count, so any external duty cycle from 20% to 60% gives the same result. All pins are plain control and status signals. No data flows through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `clk_src_select`

## Requirements
- R1: After reset, `ext_active` is 0 and `cycle_start` is 0 until the first internal period ends or a sync edge arrives.
- R2: With no sync edges, `cycle_start` pulses once every TICKS_PER_CYCLE `osc_tick` pulses (32 system clocks in the bench: 4 ticks, 8 clocks apart).
- R3: A rising edge on `sync_in` while the internal source is active raises `cycle_start` and `ext_active` together, 4 system clocks after the pin rises (two synchronizer flops, one edge register, one output register).
- R4: While locked, each external rising edge yields exactly one `cycle_start`, so the spacing of the pulses equals the external period. Pin level is ignored, and duty cycles of 20% and 60% give the same pulse count and spacing.
- R5: If MISS_LIMIT internal periods (counted from the last external edge) pass with no edge, `ext_active` falls and one `cycle_start` is emitted in that same clock. Later pulses come every internal period.
- R6: `cycle_start` is never high for two consecutive clocks. A sync edge that arrives in the clock right after an internal pulse locks the block without adding a pulse.
- R7: After a fallback, a new external rising edge locks the block again as in R3.
- R8: An external period longer than the internal period but shorter than the timeout keeps the block locked, and no internal pulses are inserted between external edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than either cycle source |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-clock tick from the internal oscillator |
| sync_in | input | 1 | Asynchronous external sync pin |
| cycle_start | output | 1 | One-clock strobe marking the start of a switching cycle |
| ext_active | output | 1 | 1 while external edges drive the cycle starts |

## Verification
The main function is tried first with no sync activity, which shows the internal cadence on its own. It is then tried with a fast external clock, with the same fast clock at 20% and at 60% duty, and with a slow external clock whose period exceeds the internal one. Comparing the two duty cycles shows that only edges matter. The slow clock shows that a missing internal period does not insert pulses while the block is locked. Stopping the edges and starting them again measures the fallback gap, shows the return to internal spacing, and exercises a second lock.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;
  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } clk_src_e;

  function automatic int cnt_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/sync_edge_detect.sv
module sync_edge_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [STAGES:0] chain;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) rise <= 1'b0;
    else        rise <= chain[STAGES-1] & ~chain[STAGES];
  end

  // R4: an edge is a single-clock event, never a level
  a_r4_rise_is_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/phase_counter.sv
module phase_counter #(
  parameter int TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  output logic expire
);
  import clk_src_pkg::*;
  localparam int PW = cnt_width(TICKS);
  localparam logic [PW-1:0] LAST = PW'(TICKS - 1);

  logic [PW-1:0] phase;

  assign expire = tick && !clr && (phase == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)               phase <= '0;
    else if (clr)             phase <= '0;
    else if (tick) begin
      if (phase == LAST)      phase <= '0;
      else                    phase <= phase + 1'b1;
    end
  end

  // R2: phase stays inside one internal period
  a_r2_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= LAST);
  // R2: a period end is followed by a fresh phase
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (phase == '0));
endmodule

// File: rtl/source_fsm.sv
module source_fsm #(
  parameter int MISS_LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_in,
  input  logic expire,
  output logic cycle_start,
  output logic ext_active
);
  import clk_src_pkg::*;
  localparam int MW = cnt_width(MISS_LIMIT);
  localparam logic [MW-1:0] MISS_LAST = MW'(MISS_LIMIT - 1);

  clk_src_e      src;
  logic [MW-1:0] miss;
  logic          cs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src  <= SRC_INT;
      miss <= '0;
      cs_q <= 1'b0;
    end else begin
      cs_q <= 1'b0;
      if (src == SRC_INT) begin
        if (edge_in) begin
          src  <= SRC_EXT;
          miss <= '0;
          cs_q <= !cs_q;
        end else if (expire) begin
          cs_q <= 1'b1;
        end
      end else begin
        if (edge_in) begin
          miss <= '0;
          cs_q <= 1'b1;
        end else if (expire) begin
          if (miss == MISS_LAST) begin
            src  <= SRC_INT;
            miss <= '0;
            cs_q <= 1'b1;
          end else begin
            miss <= miss + 1'b1;
          end
        end
      end
    end
  end

  assign cycle_start = cs_q;
  assign ext_active  = (src == SRC_EXT);

  // R1: internal periods drive the strobe when unlocked
  a_r1_internal_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_active && expire && !edge_in) |=> cycle_start);
  // R3: any sync edge leaves the block locked
  a_r3_lock: assert property (@(posedge clk) disable iff (!rst_n)
    edge_in |=> ext_active);
  // R4: each edge while locked gives one strobe
  a_r4_edge_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_active && edge_in) |=> cycle_start);
  // R5: fallback carries a strobe with it
  a_r5_fallback_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_active) |-> cycle_start);
  // R6: strobe is one clock wide
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |=> !cycle_start);
endmodule

// File: rtl/clk_src_select.sv
module clk_src_select #(
  parameter int TICKS_PER_CYCLE = 4,
  parameter int MISS_LIMIT      = 4,
  parameter int SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic sync_in,
  output logic cycle_start,
  output logic ext_active
);
  logic ext_edge;
  logic period_end;

  sync_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (sync_in),
    .rise  (ext_edge)
  );

  phase_counter #(.TICKS(TICKS_PER_CYCLE)) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (osc_tick),
    .clr    (ext_edge),
    .expire (period_end)
  );

  source_fsm #(.MISS_LIMIT(MISS_LIMIT)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .edge_in     (ext_edge),
    .expire      (period_end),
    .cycle_start (cycle_start),
    .ext_active  (ext_active)
  );
endmodule

// File: tb/clk_src_select_bench.sv
`timescale 1ns/1ps
module clk_src_select_bench;
  localparam int OSC_DIV  = 8;
  localparam int INT_PER  = 4 * OSC_DIV;
  localparam int TIMEOUT  = 4 * INT_PER;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b0;
  logic sync_in = 1'b0;
  logic cycle_start;
  logic ext_active;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_t = 0;
  int last_int = 0;
  int pulse_cnt = 0;
  int width_err = 0;
  logic prev_cs = 1'b0;

  clk_src_select u_clk_src_select (
    .clk         (clk),
    .rst_n       (rst_n),
    .osc_tick    (osc_tick),
    .sync_in     (sync_in),
    .cycle_start (cycle_start),
    .ext_active  (ext_active)
  );

  always #5 clk = ~clk;

  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      osc_tick = (k == 0);
      k = (k + 1) % OSC_DIV;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cycle_start) begin
        if (prev_cs) width_err++;
        last_int = cyc - last_t;
        last_t = cyc;
        pulse_cnt++;
      end
      prev_cs = cycle_start;
    end
  end

  task automatic check(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic check_range(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!cycle_start);
  endtask

  task automatic send_edges(input int n, input int period, input int high);
    for (int i = 0; i < n; i++) begin
      sync_in = 1'b1;
      repeat (high) @(negedge clk);
      sync_in = 1'b0;
      repeat (period - high) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 ext_active in reset", ext_active, 0);
    check("R1 cycle_start in reset", cycle_start, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ext_active after reset", ext_active, 0);
  endtask

  task automatic t_internal();
    wait_pulse();
    wait_pulse();
    wait_pulse();
    check("R2 internal interval", last_int, INT_PER);
    check("R2 still internal", ext_active, 0);
  endtask

  task automatic t_lock(input string req);
    wait_pulse();
    repeat (5) @(negedge clk);
    sync_in = 1'b1;
    repeat (4) @(negedge clk);
    check({req, " strobe 4 clocks after pin rise"}, cycle_start, 1);
    check({req, " ext_active on lock"}, ext_active, 1);
    repeat (4) @(negedge clk);
    sync_in = 1'b0;
    repeat (16) @(negedge clk);
  endtask

  task automatic t_duty(input string req, input int high);
    pulse_cnt = 0;
    send_edges(6, 24, high);
    check({req, " interval equals external period"}, last_int, 24);
    check({req, " one strobe per edge"}, pulse_cnt, 6);
    check({req, " locked"}, ext_active, 1);
  endtask

  task automatic t_slow();
    pulse_cnt = 0;
    send_edges(5, 48, 20);
    check("R8 slow interval", last_int, 48);
    check("R8 no inserted strobes", pulse_cnt, 5);
    check("R8 stays locked", ext_active, 1);
  endtask

  task automatic t_fallback();
    int t_edge;
    send_edges(1, 10, 5);
    t_edge = last_t;
    wait_pulse();
    check_range("R5 fallback gap", last_t - t_edge, TIMEOUT - OSC_DIV - 2, TIMEOUT + OSC_DIV + 2);
    check("R5 ext_active falls with strobe", ext_active, 0);
    wait_pulse();
    check("R5 internal interval after fallback", last_int, INT_PER);
    wait_pulse();
    check("R5 internal cadence continues", last_int, INT_PER);
  endtask

  initial begin
    t_reset();
    t_internal();
    t_lock("R3");
    t_duty("R4 duty 20%", 5);
    t_duty("R4 duty 60%", 14);
    t_slow();
    t_fallback();
    t_lock("R7");
    t_duty("R7 relock", 12);
    check("R6 no two-clock strobe", width_err, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule